// File: doc/BRIEF.md
# Ethernet Serial Transmit Framer

This block turns a stream of payload bytes into one 10 Mb/s Ethernet frame on a single serial line, one bit per clock. The clock is the transmit bit clock. Bytes arrive over a valid/ready stream, and each byte carries an end-of-frame flag. The framer can put the preamble and start delimiter in front of the payload. It can also pad a short payload with zero bytes and append the CRC-32 frame check sequence. Four mode pins control these steps: they switch padding on, drop the preamble, drop the check sequence, or let the framer start while carrier sense is active.

The framer drives a transmit-enable line that frames the serial bits exactly. If the collision input is seen during a frame, the framer stops the frame and sends a 32-bit jam. A latched collision flag stays high until the last jam bit has been sent. A single-cycle done pulse then reports the collision. Backoff and retransmission are left to surrounding logic, and any payload bytes that were not sent stay in the source FIFO.

Stream rules: `in_ready` is raised only in the cycle where the framer needs its next payload byte, at a byte boundary. It never depends on `in_valid`. A byte moves on a clock edge where `in_valid` and `in_ready` are both high. The source must hold a frame's bytes valid back to back; the framer never stalls the line to wait for data. The pad and no-FCS mode pins are captured when a frame starts.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is held, and on the first clock after it is released, `tx_en`, `txd`, `in_ready`, `coll_flag` and `coll_done` are all low.
- R2: A frame starts on a clock edge where the framer is idle, `tx_go` and `in_valid` are high, and either `carrier_sense` is low or `mode_ignore_cs` is high; `tx_en` is high from the next cycle. While `carrier_sense` is high and `mode_ignore_cs` is low, the framer stays idle and keeps `in_ready` low.
- R3: Unless `mode_no_preamble` is set, the frame begins with seven 0x55 bytes and then one 0xD5 byte. With `mode_no_preamble` set, the first serial bit is bit 0 of the first payload byte. Every byte is sent least significant bit first.
- R4: Payload bytes are taken only on edges with `in_valid` and `in_ready` both high. They are sent in the order received, and the byte with `in_last` high is the final payload byte of the frame.
- R5: With `mode_pad` set, a payload of fewer than 60 bytes is followed by 0x00 bytes until 60 bytes have been sent. A payload of 60 or more bytes, or any payload with `mode_pad` clear, is sent unpadded.
- R6: Unless `mode_no_fcs` is set, 32 check bits follow the payload. They are the CRC-32 of the payload plus pad bytes (reflected polynomial 0xEDB88320, register preset to all ones), complemented and sent bit 0 first. With `mode_no_fcs` set, the frame ends after the payload or pad.
- R7: `tx_en` is high for exactly the cycles that carry frame bits, and `txd` is low whenever `tx_en` is low.
- R8: If `collision` is high on an edge while `tx_en` is high and no jam is in progress, the framer sets `coll_flag` and sends 32 jam bits starting with 1 and alternating (1,0,1,0,...). `coll_flag` stays high until the last jam bit. On the next cycle `tx_en` and `coll_flag` are low and `coll_done` is high for one cycle. A collision takes priority over an abort. `collision` has no effect while idle.
- R9: If `tx_abort` is high on an edge during a frame, outside a jam, `tx_en` is low from the next cycle, with no check sequence and no jam.
- R10: If the framer needs a payload byte and `in_valid` is low, the frame ends: `tx_en` is low from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_go | input | 1 | Request to send the frame waiting in the stream |
| tx_abort | input | 1 | End the current frame at once |
| mode_pad | input | 1 | Pad short payloads to 60 bytes |
| mode_no_preamble | input | 1 | Send no preamble or start delimiter |
| mode_no_fcs | input | 1 | Append no check sequence |
| mode_ignore_cs | input | 1 | Start without waiting for carrier sense to clear |
| carrier_sense | input | 1 | Line busy indication |
| collision | input | 1 | Collision indication |
| in_valid | input | 1 | Payload byte available |
| in_ready | output | 1 | Framer takes a byte on this edge if valid |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Marks the final payload byte |
| txd | output | 1 | Serial transmit data |
| tx_en | output | 1 | High while frame bits are on `txd` |
| coll_flag | output | 1 | Latched collision, held until the jam ends |
| coll_done | output | 1 | One-cycle pulse when a jam has completed |

## Verification
The assertions assume that every input is synchronous to the bit clock. They treat `collision` and `tx_abort` as meaningful only while `tx_en` is high, and they read the start condition from `carrier_sense`, `mode_ignore_cs`, `tx_go` and `in_valid` as sampled on the starting edge. The stimulus changes inputs only just after the falling clock edge and holds the mode pins constant through each frame. It keeps `in_valid` high from the start of a frame to its flagged last byte, except in the one case that starves the framer on purpose. `collision` and `tx_abort` are given as single-cycle pulses, either in the middle of a frame or while the framer is idle.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_SFD,
    PH_DATA,
    PH_PAD,
    PH_FCS,
    PH_JAM
  } phase_t;

  localparam logic [7:0]  PRE_OCTET     = 8'h55;
  localparam logic [7:0]  SFD_OCTET     = 8'hD5;
  localparam logic [7:0]  PAD_OCTET     = 8'h00;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] JAM_WORD      = 32'h55555555;

endpackage

// File: rtl/eth_tx_crc.sv
// Bit-serial reflected CRC: one message bit folded in per enabled clock.
module eth_tx_crc #(
  parameter int          CRC_W = 32,
  parameter logic [31:0] POLY  = 32'hEDB88320
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             en,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_nxt
);

  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb      = crc_q[0] ^ bit_in;
  assign crc_nxt = {1'b0, crc_q[CRC_W-1:1]} ^ (fb ? CRC_W'(POLY) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    crc_q <= '1;
    else if (init) crc_q <= '1;
    else if (en)   crc_q <= crc_nxt;
  end

endmodule

// File: rtl/eth_tx_shreg.sv
// Right-shifting output register; each load is either one byte or a full word.
module eth_tx_shreg #(
  parameter int SR_W   = 32,
  parameter int BYTE_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            load_word,
  input  logic [SR_W-1:0] load_val,
  input  logic            run,
  output logic            bit_out,
  output logic            unit_end
);

  localparam int CW = $clog2(SR_W);
  localparam logic [CW-1:0] WORD_LAST = CW'(SR_W - 1);
  localparam logic [CW-1:0] BYTE_LAST = CW'(BYTE_W - 1);

  logic [SR_W-1:0] sr_q;
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   lim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load) begin
      sr_q  <= load_val;
      cnt_q <= '0;
      lim_q <= load_word ? WORD_LAST : BYTE_LAST;
    end else if (run) begin
      sr_q  <= {1'b0, sr_q[SR_W-1:1]};
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign bit_out  = sr_q[0];
  assign unit_end = (cnt_q == lim_q);

endmodule

// File: rtl/eth_tx_ctrl.sv
// Frame sequencer: picks the next unit to serialize at each unit boundary.
module eth_tx_ctrl
  import eth_tx_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int SR_W    = 32,
  parameter int MIN_LEN = 60,
  parameter int PRE_LEN = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_go,
  input  logic              tx_abort,
  input  logic              mode_pad,
  input  logic              mode_no_preamble,
  input  logic              mode_no_fcs,
  input  logic              mode_ignore_cs,
  input  logic              carrier_sense,
  input  logic              collision,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              unit_end,
  input  logic [SR_W-1:0]   crc_nxt,
  output logic              ld,
  output logic              ld_word,
  output logic [SR_W-1:0]   ld_val,
  output logic              crc_init,
  output logic              crc_en,
  output logic              busy,
  output logic              coll_flag,
  output logic              coll_done
);

  localparam int LCW = $clog2(MIN_LEN + 1);
  localparam int PCW = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;
  localparam logic [LCW-1:0] MIN_CNT  = LCW'(MIN_LEN);
  localparam logic [PCW-1:0] PRE_LAST = PCW'(PRE_LEN - 1);

  function automatic logic [SR_W-1:0] widen(input logic [BYTE_W-1:0] b);
    return {{(SR_W - BYTE_W){1'b0}}, b};
  endfunction

  phase_t           ph_q, ph_n;
  logic [PCW-1:0]   pre_q, pre_n;
  logic [LCW-1:0]   len_q, len_n, len_inc;
  logic             last_q, last_n;
  logic             mpad_q, mpad_n;
  logic             mnofcs_q, mnofcs_n;
  logic             cflag_q, cflag_n;
  logic             cdone_q, cdone_n;
  logic             cs_ok, need_byte, pad_more, end_pl, active;
  logic [SR_W-1:0]  data_val;

  assign active   = (ph_q != PH_IDLE);
  assign cs_ok    = mode_ignore_cs || !carrier_sense;
  assign len_inc  = (len_q < MIN_CNT) ? len_q + LCW'(1) : len_q;
  assign pad_more = mpad_q && (len_q < MIN_CNT);
  assign data_val = widen(in_data);

  // Byte demand comes only from the phase and the unit boundary.
  always_comb begin
    unique case (ph_q)
      PH_IDLE: need_byte = tx_go && cs_ok && mode_no_preamble;
      PH_SFD:  need_byte = unit_end;
      PH_DATA: need_byte = unit_end && !last_q;
      default: need_byte = 1'b0;
    endcase
  end

  assign in_ready = need_byte && !(active && (collision || tx_abort));

  always_comb begin
    ph_n     = ph_q;
    pre_n    = pre_q;
    len_n    = len_q;
    last_n   = last_q;
    mpad_n   = mpad_q;
    mnofcs_n = mnofcs_q;
    cflag_n  = cflag_q;
    cdone_n  = 1'b0;
    ld       = 1'b0;
    ld_word  = 1'b0;
    ld_val   = '0;
    crc_init = 1'b0;
    end_pl   = 1'b0;

    unique case (ph_q)
      PH_IDLE: begin
        if (tx_go && cs_ok && in_valid) begin
          crc_init = 1'b1;
          mpad_n   = mode_pad;
          mnofcs_n = mode_no_fcs;
          ld       = 1'b1;
          if (mode_no_preamble) begin
            ld_val = data_val;
            last_n = in_last;
            len_n  = LCW'(1);
            ph_n   = PH_DATA;
          end else begin
            ld_val = widen(BYTE_W'(PRE_OCTET));
            pre_n  = '0;
            ph_n   = PH_PRE;
          end
        end
      end
      default: begin
        if (collision && ph_q != PH_JAM) begin
          ph_n    = PH_JAM;
          ld      = 1'b1;
          ld_word = 1'b1;
          ld_val  = SR_W'(JAM_WORD);
          cflag_n = 1'b1;
        end else if (tx_abort && ph_q != PH_JAM) begin
          ph_n = PH_IDLE;
        end else if (unit_end) begin
          case (ph_q)
            PH_PRE: begin
              ld = 1'b1;
              if (pre_q == PRE_LAST) begin
                ld_val = widen(BYTE_W'(SFD_OCTET));
                ph_n   = PH_SFD;
              end else begin
                ld_val = widen(BYTE_W'(PRE_OCTET));
                pre_n  = pre_q + PCW'(1);
              end
            end
            PH_SFD: begin
              if (in_valid) begin
                ld     = 1'b1;
                ld_val = data_val;
                last_n = in_last;
                len_n  = LCW'(1);
                ph_n   = PH_DATA;
              end else begin
                ph_n = PH_IDLE;
              end
            end
            PH_DATA: begin
              if (last_q) begin
                end_pl = 1'b1;
              end else if (in_valid) begin
                ld     = 1'b1;
                ld_val = data_val;
                last_n = in_last;
                len_n  = len_inc;
              end else begin
                ph_n = PH_IDLE;
              end
            end
            PH_PAD: end_pl = 1'b1;
            PH_JAM: begin
              ph_n    = PH_IDLE;
              cflag_n = 1'b0;
              cdone_n = 1'b1;
            end
            default: ph_n = PH_IDLE;
          endcase

          if (end_pl) begin
            if (pad_more) begin
              ld     = 1'b1;
              ld_val = widen(BYTE_W'(PAD_OCTET));
              len_n  = len_inc;
              ph_n   = PH_PAD;
            end else if (!mnofcs_q) begin
              ld      = 1'b1;
              ld_word = 1'b1;
              ld_val  = ~crc_nxt;
              ph_n    = PH_FCS;
            end else begin
              ph_n = PH_IDLE;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      pre_q    <= '0;
      len_q    <= '0;
      last_q   <= 1'b0;
      mpad_q   <= 1'b0;
      mnofcs_q <= 1'b0;
      cflag_q  <= 1'b0;
      cdone_q  <= 1'b0;
    end else begin
      ph_q     <= ph_n;
      pre_q    <= pre_n;
      len_q    <= len_n;
      last_q   <= last_n;
      mpad_q   <= mpad_n;
      mnofcs_q <= mnofcs_n;
      cflag_q  <= cflag_n;
      cdone_q  <= cdone_n;
    end
  end

  assign crc_en    = (ph_q == PH_DATA) || (ph_q == PH_PAD);
  assign busy      = active;
  assign coll_flag = cflag_q;
  assign coll_done = cdone_q;

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
  parameter int BYTE_W  = 8,
  parameter int FCS_W   = 32,
  parameter int MIN_LEN = 60,
  parameter int PRE_LEN = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_go,
  input  logic              tx_abort,
  input  logic              mode_pad,
  input  logic              mode_no_preamble,
  input  logic              mode_no_fcs,
  input  logic              mode_ignore_cs,
  input  logic              carrier_sense,
  input  logic              collision,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              txd,
  output logic              tx_en,
  output logic              coll_flag,
  output logic              coll_done
);

  logic             ld, ld_word, crc_init, crc_en, busy, bit_out, unit_end;
  logic [FCS_W-1:0] ld_val, crc_nxt;

  eth_tx_ctrl #(
    .BYTE_W (BYTE_W),
    .SR_W   (FCS_W),
    .MIN_LEN(MIN_LEN),
    .PRE_LEN(PRE_LEN)
  ) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .tx_go           (tx_go),
    .tx_abort        (tx_abort),
    .mode_pad        (mode_pad),
    .mode_no_preamble(mode_no_preamble),
    .mode_no_fcs     (mode_no_fcs),
    .mode_ignore_cs  (mode_ignore_cs),
    .carrier_sense   (carrier_sense),
    .collision       (collision),
    .in_valid        (in_valid),
    .in_data         (in_data),
    .in_last         (in_last),
    .in_ready        (in_ready),
    .unit_end        (unit_end),
    .crc_nxt         (crc_nxt),
    .ld              (ld),
    .ld_word         (ld_word),
    .ld_val          (ld_val),
    .crc_init        (crc_init),
    .crc_en          (crc_en),
    .busy            (busy),
    .coll_flag       (coll_flag),
    .coll_done       (coll_done)
  );

  eth_tx_shreg #(
    .SR_W  (FCS_W),
    .BYTE_W(BYTE_W)
  ) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld),
    .load_word(ld_word),
    .load_val (ld_val),
    .run      (busy),
    .bit_out  (bit_out),
    .unit_end (unit_end)
  );

  eth_tx_crc #(
    .CRC_W(FCS_W),
    .POLY (eth_tx_pkg::CRC_POLY_REFL)
  ) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (crc_init),
    .en     (crc_en),
    .bit_in (bit_out),
    .crc_nxt(crc_nxt)
  );

  assign tx_en = busy;
  assign txd   = busy & bit_out;

endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_go,
  input logic tx_abort,
  input logic mode_no_preamble,
  input logic mode_ignore_cs,
  input logic carrier_sense,
  input logic collision,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic tx_en,
  input logic coll_flag,
  input logic coll_done
);

  assert_line_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !txd);

  assert_start_defers_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> ($past(mode_ignore_cs) || !$past(carrier_sense)) && $past(tx_go) && $past(in_valid));

  assert_ready_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !tx_en) |-> (mode_no_preamble && tx_go));

  assert_coll_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (collision && tx_en && !coll_flag) |=> coll_flag);

  assert_coll_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    coll_flag |=> (coll_flag || coll_done));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    coll_done |-> (!tx_en && !coll_flag));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    coll_done |=> !coll_done);

  assert_abort_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_abort && tx_en && !coll_flag && !collision) |=> !tx_en);

endmodule

bind eth_tx_framer eth_tx_framer_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .tx_go           (tx_go),
  .tx_abort        (tx_abort),
  .mode_no_preamble(mode_no_preamble),
  .mode_ignore_cs  (mode_ignore_cs),
  .carrier_sense   (carrier_sense),
  .collision       (collision),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .txd             (txd),
  .tx_en           (tx_en),
  .coll_flag       (coll_flag),
  .coll_done       (coll_done)
);

// File: tb/eth_tx_framer_tb.sv
`timescale 1ns/1ps
module eth_tx_framer_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_go = 0, tx_abort = 0, mode_pad = 0, mode_no_preamble = 0;
  logic mode_no_fcs = 0, mode_ignore_cs = 0, carrier_sense = 0, collision = 0;
  logic in_valid, in_ready, in_last, txd, tx_en, coll_flag, coll_done;
  logic [7:0] in_data;

  always #5 clk = ~clk;

  eth_tx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .tx_abort(tx_abort),
    .mode_pad(mode_pad), .mode_no_preamble(mode_no_preamble),
    .mode_no_fcs(mode_no_fcs), .mode_ignore_cs(mode_ignore_cs),
    .carrier_sense(carrier_sense), .collision(collision),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .txd(txd), .tx_en(tx_en),
    .coll_flag(coll_flag), .coll_done(coll_done)
  );

  // Source FIFO model
  logic [7:0] mem   [0:4095];
  logic       lastm [0:4095];
  logic [11:0] ptr;
  int fifo_end = 0;

  assign in_valid = (int'(ptr) < fifo_end);
  assign in_data  = mem[ptr];
  assign in_last  = lastm[ptr];

  always @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (in_valid && in_ready) ptr <= ptr + 12'd1;
  end

  // Line monitor
  logic cap [0:4095];
  int cap_n = 0;
  int idle_bad = 0;
  int done_cnt = 0;
  always @(negedge clk) begin
    if (tx_en) begin
      cap[cap_n] = txd;
      cap_n = cap_n + 1;
    end
    if (!tx_en && txd) idle_bad = idle_bad + 1;
    if (coll_done) done_cnt = done_cnt + 1;
  end

  // Expected frame
  logic exp_bits [0:4095];
  int exp_n;
  logic [31:0] bcrc;

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  function automatic void push_byte(input logic [7:0] b, input bit upd);
    for (int i = 0; i < 8; i++) begin
      exp_bits[exp_n] = b[i];
      exp_n++;
      if (upd) bcrc = (bcrc >> 1) ^ (((bcrc[0] ^ b[i]) == 1'b1) ? 32'hEDB88320 : 32'h0);
    end
  endfunction

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 29 + seed * 7 + 3) ^ 8'hA5);
  endfunction

  task automatic load_fifo(input int n, input int seed, input bit mark_last);
    int base;
    base = int'(ptr);
    for (int i = 0; i < n; i++) begin
      mem[base + i]   = pat(i, seed);
      lastm[base + i] = mark_last && (i == n - 1);
    end
    fifo_end = base + n;
  endtask

  task automatic build_exp(input int n, input int seed, input bit pad, input bit nopre, input bit nofcs);
    logic [31:0] f;
    exp_n = 0;
    bcrc  = 32'hFFFFFFFF;
    if (!nopre) begin
      for (int i = 0; i < 7; i++) push_byte(8'h55, 1'b0);
      push_byte(8'hD5, 1'b0);
    end
    for (int i = 0; i < n; i++) push_byte(pat(i, seed), 1'b1);
    if (pad) for (int i = n; i < 60; i++) push_byte(8'h00, 1'b1);
    if (!nofcs) begin
      f = ~bcrc;
      for (int k = 0; k < 4; k++) push_byte(f[8*k +: 8], 1'b0);
    end
  endtask

  task automatic compare(input string req, input int upto);
    int bad;
    bad = -1;
    for (int i = 0; i < upto; i++)
      if (bad < 0 && i < cap_n && cap[i] !== exp_bits[i]) bad = i;
    chk(bad < 0, req, "first mismatching bit index", bad, -1);
  endtask

  task automatic send_and_wait();
    tx_go = 1'b1;
    while (!tx_en) tick();
    tx_go = 1'b0;
    while (tx_en) tick();
  endtask

  task automatic run_frame(input string req, input int n, input bit pad, input bit nopre,
                           input bit nofcs, input int seed);
    int start_ptr;
    tick();
    load_fifo(n, seed, 1'b1);
    start_ptr = int'(ptr);
    build_exp(n, seed, pad, nopre, nofcs);
    mode_pad = pad; mode_no_preamble = nopre; mode_no_fcs = nofcs;
    cap_n = 0;
    send_and_wait();
    chk(cap_n == exp_n, req, "frame length in bits (R7 tx_en window)", cap_n, exp_n);
    compare(req, exp_n);
    chk(int'(ptr) - start_ptr == n, req, "bytes taken from stream (R4)", int'(ptr) - start_ptr, n);
    mode_pad = 0; mode_no_preamble = 0; mode_no_fcs = 0;
  endtask

  task automatic t_reset();
    tick();
    chk(!tx_en && !txd && !in_ready && !coll_flag && !coll_done, "R1", "outputs in reset",
        {tx_en, txd, in_ready, coll_flag, coll_done}, 0);
    rst_n = 1'b1;
    tick();
    chk(!tx_en && !txd && !in_ready && !coll_flag && !coll_done, "R1", "outputs after reset",
        {tx_en, txd, in_ready, coll_flag, coll_done}, 0);
  endtask

  task automatic t_carrier();
    int bad;
    bad = 0;
    tick();
    load_fifo(20, 5, 1'b1);
    build_exp(20, 5, 1'b1, 1'b0, 1'b0);
    mode_pad = 1; carrier_sense = 1; mode_ignore_cs = 0; mode_no_preamble = 1;
    tx_go = 1;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (tx_en || in_ready) bad++;
    end
    chk(bad == 0, "R2", "cycles active while carrier busy", bad, 0);
    mode_no_preamble = 0;
    cap_n = 0;
    carrier_sense = 0;
    tick();
    chk(tx_en == 1'b1, "R2", "tx_en one cycle after carrier clears", tx_en, 1);
    tx_go = 0;
    while (tx_en) tick();
    chk(cap_n == exp_n, "R2", "frame length after deferral", cap_n, exp_n);
    // override mode
    tick();
    load_fifo(20, 6, 1'b1);
    build_exp(20, 6, 1'b1, 1'b0, 1'b0);
    carrier_sense = 1; mode_ignore_cs = 1;
    cap_n = 0;
    tx_go = 1;
    tick();
    chk(tx_en == 1'b1, "R2", "start despite carrier in override mode", tx_en, 1);
    tx_go = 0;
    while (tx_en) tick();
    compare("R2", exp_n);
    carrier_sense = 0; mode_ignore_cs = 0; mode_pad = 0;
  endtask

  task automatic t_collision();
    int pos, dc, alt_bad;
    tick();
    load_fifo(64, 9, 1'b1);
    build_exp(64, 9, 1'b0, 1'b0, 1'b0);
    cap_n = 0;
    dc = done_cnt;
    tx_go = 1;
    while (cap_n < 120) tick();
    tx_go = 0;
    pos = cap_n;
    collision = 1;
    tick();
    collision = 0;
    chk(coll_flag == 1'b1, "R8", "flag set after collision pulse", coll_flag, 1);
    while (tx_en) begin
      if (!coll_flag) alt_bad++;
      tick();
    end
    chk(cap_n == pos + 32, "R8", "bits on line incl. jam", cap_n, pos + 32);
    compare("R8", pos);
    alt_bad = 0;
    for (int i = 0; i < 32; i++)
      if (pos + i < cap_n && cap[pos + i] !== ((i % 2) == 0)) alt_bad++;
    chk(alt_bad == 0, "R8", "jam bits off the alternating pattern", alt_bad, 0);
    chk(coll_flag == 1'b0, "R8", "flag clear after jam", coll_flag, 0);
    chk(done_cnt - dc == 1, "R8", "done pulses", done_cnt - dc, 1);
    // collision while idle has no effect
    dc = done_cnt;
    collision = 1;
    tick();
    collision = 0;
    tick();
    tick();
    chk(!coll_flag && !tx_en && done_cnt == dc, "R8", "idle collision effect",
        {coll_flag, tx_en}, 0);
  endtask

  task automatic t_abort();
    int pos, dc;
    tick();
    load_fifo(64, 11, 1'b1);
    cap_n = 0;
    dc = done_cnt;
    tx_go = 1;
    while (cap_n < 80) tick();
    tx_go = 0;
    pos = cap_n;
    tx_abort = 1;
    tick();
    tx_abort = 0;
    chk(tx_en == 1'b0, "R9", "tx_en after abort", tx_en, 0);
    chk(cap_n == pos, "R9", "bits after abort", cap_n, pos);
    chk(!coll_flag && done_cnt == dc, "R9", "jam activity after abort", coll_flag, 0);
  endtask

  task automatic t_underrun();
    tick();
    load_fifo(5, 13, 1'b0);
    build_exp(5, 13, 1'b0, 1'b0, 1'b1);
    cap_n = 0;
    send_and_wait();
    chk(cap_n == 104, "R10", "bits sent before starvation", cap_n, 104);
    compare("R10", 104);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    run_frame("R3 R4 R6", 64, 1'b1, 1'b0, 1'b0, 1);
    run_frame("R5", 10, 1'b1, 1'b0, 1'b0, 2);
    run_frame("R5", 10, 1'b0, 1'b0, 1'b0, 3);
    run_frame("R5", 60, 1'b1, 1'b0, 1'b0, 4);
    run_frame("R5", 59, 1'b1, 1'b0, 1'b0, 7);
    run_frame("R3", 20, 1'b1, 1'b1, 1'b0, 8);
    run_frame("R6", 12, 1'b0, 1'b0, 1'b1, 10);
    t_carrier();
    t_collision();
    t_abort();
    t_underrun();
    chk(idle_bad == 0, "R7", "txd high while tx_en low", idle_bad, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule